// File: doc/BRIEF.md
# Non-Leaky Integrate-and-Fire Neuron Bank

This block holds the membrane potentials of a spiking layer and updates them in integer arithmetic with no decay. Neurons are arranged in groups of sixteen that are updated in parallel, one group per accepted transfer. A group can receive two kinds of contribution. The first is a synaptic current vector, one value per neuron, coming from a weight tile. The second is a vector of external input values that go straight into the membranes without passing through any weights. Several transfers to the same group within one timestep accumulate. Every sum saturates at the signed range of the potential instead of wrapping.

A one-cycle end-of-timestep strobe closes the timestep. In that cycle every neuron of every group compares its potential with a programmable threshold. A neuron fires when its potential is at or above the threshold, and a neuron that fires is cleared to zero. A neuron that does not fire keeps its potential unchanged. The resulting spike vector is registered on the strobe edge and held for the whole of the following timestep, so a spike produced in one timestep is consumed one timestep later.

Both contribution inputs are valid/ready streams. A transfer happens on a rising clock edge when valid and ready are both high. Ready drops only during the cycle in which the end-of-timestep strobe is high. A sender that sees ready low must hold its valid, group and data unchanged, and the transfer then lands in the new timestep on the next edge. The strobe and the threshold are plain control inputs, and the spike vector is a plain status output.

Top module: `if_neuron_bank`

## Requirements
- R1: After reset every membrane potential is zero, the spike vector is all zero and both ready outputs are high while the strobe is low.
- R2: On an accepted synaptic transfer, neuron n of the addressed group (group index on syn_group_i, current of neuron n in bits [16n+15:16n] of syn_cur_i, two's complement) gains that current, and neurons of other groups do not change. Transfers to one group within one timestep accumulate.
- R3: On an accepted input transfer, the values on inj_val_i (same per-neuron bit layout) are added directly to the addressed group's potentials. If both streams transfer to the same group in the same cycle, the potential gains both values.
- R4: A sum above 32767 leaves the potential at 32767. Further positive contributions keep it there.
- R5: A sum below -32768 leaves the potential at -32768.
- R6: On the edge where eot_i is high, spike bit g*16+n of spikes_o is set exactly when neuron n of group g holds a potential greater than or equal to thr_i, compared as signed numbers.
- R7: On that edge a neuron that fires is cleared to zero and a neuron that does not fire keeps its potential. Outside that edge a neuron with no accepted transfer keeps its potential.
- R8: While eot_i is high, syn_ready_o and inj_ready_o are low and no transfer is accepted. A held transfer is accepted on the next edge with the strobe low.
- R9: spikes_o changes only on an edge where eot_i is high and otherwise holds its value through the timestep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_i | input | 16 | Signed firing threshold, sampled on the strobe edge |
| eot_i | input | 1 | End-of-timestep strobe, one cycle |
| syn_valid_i | input | 1 | Synaptic current transfer valid |
| syn_ready_o | output | 1 | Synaptic stream ready |
| syn_group_i | input | 2 | Target neuron group of the synaptic transfer |
| syn_cur_i | input | 256 | Sixteen signed 16-bit currents |
| inj_valid_i | input | 1 | Direct input transfer valid |
| inj_ready_o | output | 1 | Direct input stream ready |
| inj_group_i | input | 2 | Target neuron group of the input transfer |
| inj_val_i | input | 256 | Sixteen signed 16-bit input values |
| spikes_o | output | 64 | Spike vector of all groups from the last timestep |

## Verification
Two pairs of functions can fall in the same cycle. The first is accumulation and end of timestep. The bench raises the strobe while a synaptic transfer is still valid. It then checks that ready is low and that the threshold result does not include that current. A later strobe shows that the current was added exactly once. The second pair is the two streams hitting one group on one edge. Their joint sum is judged against a bench model of the potentials, including a case that drives the joint sum past the positive limit, where only saturation explains the spike pattern seen.

// File: rtl/snb_pkg.sv
package snb_pkg;

  // Per-neuron action chosen for the next clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ADD   = 2'd1,
    ACT_RESET = 2'd2
  } nrn_act_e;

endpackage

// File: rtl/snb_sat_add.sv
module snb_sat_add #(
  parameter int POT_W = 16,
  parameter int CUR_W = 16
) (
  input  logic signed [POT_W-1:0] base_i,
  input  logic signed [CUR_W-1:0] a_i,
  input  logic signed [CUR_W-1:0] b_i,
  output logic signed [POT_W-1:0] sum_o
);

  // Two guard bits cover a three-operand sum without overflow
  localparam int SW = ((POT_W > CUR_W) ? POT_W : CUR_W) + 2;
  localparam logic signed [SW-1:0] MAXV = {{(SW-POT_W+1){1'b0}}, {(POT_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-POT_W+1){1'b1}}, {(POT_W-1){1'b0}}};

  logic signed [SW-1:0] wide;

  always_comb begin
    wide = SW'(base_i) + SW'(a_i) + SW'(b_i);
    if (wide > MAXV) begin
      sum_o = MAXV[POT_W-1:0];
    end else if (wide < MINV) begin
      sum_o = MINV[POT_W-1:0];
    end else begin
      sum_o = wide[POT_W-1:0];
    end
  end

endmodule

// File: rtl/snb_neuron.sv
module snb_neuron
  import snb_pkg::*;
#(
  parameter int POT_W = 16,
  parameter int CUR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    syn_en_i,
  input  logic signed [CUR_W-1:0] syn_cur_i,
  input  logic                    inj_en_i,
  input  logic signed [CUR_W-1:0] inj_val_i,
  input  logic                    eot_i,
  input  logic signed [POT_W-1:0] thr_i,
  output logic                    fire_o
);

  logic signed [POT_W-1:0] pot_q;
  logic signed [POT_W-1:0] sum;
  logic signed [CUR_W-1:0] op_a;
  logic signed [CUR_W-1:0] op_b;
  nrn_act_e                act;

  assign op_a   = syn_en_i ? syn_cur_i : '0;
  assign op_b   = inj_en_i ? inj_val_i : '0;
  assign fire_o = (pot_q >= thr_i);

  snb_sat_add #(
    .POT_W (POT_W),
    .CUR_W (CUR_W)
  ) u_add (
    .base_i (pot_q),
    .a_i    (op_a),
    .b_i    (op_b),
    .sum_o  (sum)
  );

  always_comb begin
    if (eot_i && fire_o) begin
      act = ACT_RESET;
    end else if (syn_en_i || inj_en_i) begin
      act = ACT_ADD;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pot_q <= '0;
    end else begin
      case (act)
        ACT_ADD:   pot_q <= sum;
        ACT_RESET: pot_q <= '0;
        default:   pot_q <= pot_q;
      endcase
    end
  end

  // R7
  fire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_i && fire_o) |=> (pot_q == '0));

  // R7
  no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eot_i && !syn_en_i && !inj_en_i) |=> $stable(pot_q));

  // R4
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ADD && op_a >= 0 && op_b >= 0) |=> (pot_q >= $past(pot_q)));

  // R5
  sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ADD && op_a <= 0 && op_b <= 0) |=> (pot_q <= $past(pot_q)));

endmodule

// File: rtl/if_neuron_bank.sv
module if_neuron_bank #(
  parameter int NEURONS = 16,
  parameter int GROUPS  = 4,
  parameter int POT_W   = 16,
  parameter int CUR_W   = 16,
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [POT_W-1:0]         thr_i,
  input  logic                     eot_i,
  input  logic                     syn_valid_i,
  output logic                     syn_ready_o,
  input  logic [GW-1:0]            syn_group_i,
  input  logic [NEURONS*CUR_W-1:0] syn_cur_i,
  input  logic                     inj_valid_i,
  output logic                     inj_ready_o,
  input  logic [GW-1:0]            inj_group_i,
  input  logic [NEURONS*CUR_W-1:0] inj_val_i,
  output logic [GROUPS*NEURONS-1:0] spikes_o
);

  localparam int TOTAL = GROUPS * NEURONS;

  logic              syn_take;
  logic              inj_take;
  logic [TOTAL-1:0]  fire;
  logic [TOTAL-1:0]  spikes_q;

  // The timestep boundary owns the membranes for its cycle
  assign syn_ready_o = !eot_i;
  assign inj_ready_o = !eot_i;
  assign syn_take    = syn_valid_i && syn_ready_o;
  assign inj_take    = inj_valid_i && inj_ready_o;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic syn_hit;
    logic inj_hit;
    assign syn_hit = syn_take && (syn_group_i == GW'(g));
    assign inj_hit = inj_take && (inj_group_i == GW'(g));

    for (genvar n = 0; n < NEURONS; n++) begin : g_nrn
      snb_neuron #(
        .POT_W (POT_W),
        .CUR_W (CUR_W)
      ) u_nrn (
        .clk       (clk),
        .rst_n     (rst_n),
        .syn_en_i  (syn_hit),
        .syn_cur_i (syn_cur_i[n*CUR_W +: CUR_W]),
        .inj_en_i  (inj_hit),
        .inj_val_i (inj_val_i[n*CUR_W +: CUR_W]),
        .eot_i     (eot_i),
        .thr_i     (thr_i),
        .fire_o    (fire[g*NEURONS + n])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spikes_q <= '0;
    end else if (eot_i) begin
      spikes_q <= fire;
    end
  end

  assign spikes_o = spikes_q;

  // R9
  spike_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eot_i |=> $stable(spikes_o));

endmodule

// File: tb/test_if_neuron_bank.sv
module test_if_neuron_bank;

  localparam int N  = 16;
  localparam int G  = 4;
  localparam int W  = 16;

  typedef struct packed {
    logic [1:0]        op;    // 0 syn, 1 inj, 2 both, 3 end of timestep
    logic [1:0]        grp;
    logic signed [15:0] base;
    logic signed [7:0]  step;
    logic signed [15:0] thr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0,  16'sd100,  8'sd30, 16'sd0},
    '{2'd0, 2'd0,  16'sd200,  8'sd0,  16'sd0},
    '{2'd1, 2'd1,  16'sd490,  8'sd1,  16'sd0},
    '{2'd2, 2'd2,  16'sd250,  8'sd2,  16'sd0},
    '{2'd3, 2'd0,  16'sd0,    8'sd0,  16'sd500},
    '{2'd0, 2'd0,  16'sd50,  -8'sd10, 16'sd0},
    '{2'd0, 2'd3, -16'sd100,  8'sd0,  16'sd0},
    '{2'd1, 2'd1,  16'sd20,   8'sd0,  16'sd0},
    '{2'd3, 2'd0,  16'sd0,    8'sd0,  16'sd500},
    '{2'd3, 2'd0,  16'sd0,    8'sd0,  16'sd100},
    '{2'd2, 2'd3, -16'sd30,   8'sd5,  16'sd0},
    '{2'd3, 2'd0,  16'sd0,    8'sd0, -16'sd50}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [W-1:0]     thr = '0;
  logic             eot = 1'b0;
  logic             syn_valid = 1'b0;
  logic             syn_ready;
  logic [1:0]       syn_group = '0;
  logic [N*W-1:0]   syn_cur = '0;
  logic             inj_valid = 1'b0;
  logic             inj_ready;
  logic [1:0]       inj_group = '0;
  logic [N*W-1:0]   inj_val = '0;
  logic [G*N-1:0]   spikes;

  int checks = 0;
  int fails = 0;
  int pot [G][N];
  logic [G*N-1:0] exp_spk = '0;

  always #5 clk = ~clk;

  if_neuron_bank #(.NEURONS(N), .GROUPS(G), .POT_W(W), .CUR_W(W)) i_if_neuron_bank (
    .clk(clk), .rst_n(rst_n), .thr_i(thr), .eot_i(eot),
    .syn_valid_i(syn_valid), .syn_ready_o(syn_ready), .syn_group_i(syn_group), .syn_cur_i(syn_cur),
    .inj_valid_i(inj_valid), .inj_ready_o(inj_ready), .inj_group_i(inj_group), .inj_val_i(inj_val),
    .spikes_o(spikes)
  );

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [N*W-1:0] pack(int base, int step);
    logic [N*W-1:0] v;
    for (int n = 0; n < N; n++) v[n*W +: W] = W'(base + step * n);
    return v;
  endfunction

  task automatic chk(string req, logic [G*N-1:0] act, logic [G*N-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Called at a negedge; one edge later the transfer is taken and the model updated
  task automatic accum(int op, int g, int base, int step);
    syn_valid = (op == 0 || op == 2);
    inj_valid = (op == 1 || op == 2);
    syn_group = 2'(g);
    inj_group = 2'(g);
    syn_cur   = pack(base, step);
    inj_val   = pack(base, step);
    @(negedge clk);
    syn_valid = 1'b0;
    inj_valid = 1'b0;
    for (int n = 0; n < N; n++) begin
      int c;
      c = int'($signed(W'(base + step * n)));
      pot[g][n] = sat(pot[g][n] + ((op == 2) ? 2 * c : c));
    end
  endtask

  function automatic void model_eot(int t);
    for (int g = 0; g < G; g++)
      for (int n = 0; n < N; n++) begin
        exp_spk[g*N+n] = (pot[g][n] >= t);
        if (pot[g][n] >= t) pot[g][n] = 0;
      end
  endfunction

  task automatic end_ts(int t, string req);
    thr = W'(t);
    eot = 1'b1;
    @(negedge clk);
    eot = 1'b0;
    model_eot(t);
    chk(req, spikes, exp_spk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int g = 0; g < G; g++)
      for (int n = 0; n < N; n++) pot[g][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of spikes and ready
    chk("R1 spikes after reset", spikes, '0);
    chk("R1 ready after reset", {62'd0, syn_ready, inj_ready}, 64'd3);
    // R1: zero potentials stay below threshold 1 and meet threshold 0
    end_ts(1, "R1 zero potential below 1");
    end_ts(0, "R1 zero potential meets 0");

    // Table walk: R2 R3 R6 R7 accumulation and thresholding patterns
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd3)
        end_ts(int'(VECS[i].thr), "R6 R7 table timestep");
      else
        accum(int'(VECS[i].op), int'(VECS[i].grp), int'(VECS[i].base), int'(VECS[i].step));
    end

    // Clear everything with the minimum threshold
    end_ts(-32768, "R6 minimum threshold fires all");

    // R9: spikes hold while transfers land mid-timestep
    accum(0, 1, 300, 0);
    chk("R9 spikes held after syn", spikes, exp_spk);
    accum(1, 1, 300, 0);
    chk("R9 spikes held after inj", spikes, exp_spk);
    end_ts(600, "R2 R3 group1 accumulates to 600");

    // R8: strobe and transfer in the same cycle
    end_ts(-32768, "R7 clear before conflict");
    syn_valid = 1'b1;
    syn_group = 2'd0;
    syn_cur   = pack(60, 0);
    thr = W'(50);
    eot = 1'b1;
    #1;
    chk("R8 ready low on strobe", {62'd0, syn_ready, inj_ready}, 64'd0);
    @(negedge clk);
    eot = 1'b0;
    model_eot(50);
    chk("R8 stalled current not in timestep", spikes, exp_spk);
    @(negedge clk);
    syn_valid = 1'b0;
    for (int n = 0; n < N; n++) pot[0][n] = sat(pot[0][n] + 60);
    end_ts(100, "R8 held transfer taken once");
    end_ts(60, "R8 held transfer reaches 60");

    // R4: joint transfer beyond positive limit, then more positive input
    end_ts(-32768, "R7 clear before saturation");
    accum(2, 3, 20000, 0);
    accum(0, 3, 1, 0);
    end_ts(32767, "R4 positive saturation");

    // R5: negative saturation, wrap would fire against -32767
    accum(0, 2, -20000, 0);
    accum(0, 2, -20000, 0);
    end_ts(-32767, "R5 negative saturation no fire");
    accum(0, 2, 1, 0);
    end_ts(-32767, "R5 saturated value plus one");

    summary();
  end

endmodule